// File: doc/BRIEF.md
# Bitplane Tile Pixel Plotter

This block writes one pixel into a frame buffer that is organised as 8x8 tiles of planar bytes in a byte-wide RAM. The caller gives a y coordinate, an 8-bit colour, an option byte and a colour depth of 2, 4 or 8 bits per pixel, then pulses start. The x coordinate lives inside the block. It can be loaded while idle, and it steps by one after every plot, so a run of starts draws a horizontal span.

The block first picks the effective colour. An option bit enables checkerboard dithering between the two nibbles, and a transparency rule can drop the plot. For each bitplane it then reads the byte that holds the pixel and writes it back with only the pixel's bit changed. A single done pulse marks the end. The tile base address is a linear function of the tile row and column. A screen-line count output tells the caller whether sprite mode is in effect.

Top module: `tile_plotter`

## Requirements
- R1: After reset, x_o is 0, done_o, busy_o, mem_re_o and mem_we_o are 0.
- R2: With option bit 1 set, the effective colour is colour bits 7:4 (zero-extended) when bit 0 of (x XOR y) is 1, and colour bits 7:0 otherwise; with option bit 1 clear it is colour bits 7:0.
- R3: With option bit 0 clear and effective colour bits 3:0 all zero, the plot performs no RAM access; with option bit 0 set, a zero colour is still written.
- R4: In 8-bit depth with option bit 4 set, the transparency test of R3 uses all 8 bits of the effective colour instead of bits 3:0.
- R5: Each write sets or clears only bit (7 - x mod 8) of the byte read, according to the plane's colour bit, and keeps the other seven bits.
- R6: The address of plane p is ((y/8)*TILES_PER_ROW + x/8) * B + 2*(y mod 8) + 16*(p/2) + (p mod 2), where B is 16, 32 or 64 for depth codes 0, 1, 2, truncated to ADDR_W bits. Effective colour bit p goes to plane p.
- R7: Depth code 0 updates planes 0 to 1, code 1 updates planes 0 to 3, and code 2 (or 3) updates planes 0 to 7, in ascending plane order.
- R8: Each plane takes one read cycle (mem_re_o) followed by one write cycle (mem_we_o) to the same address. done_o is high for exactly one cycle: the cycle after the last write, or the cycle after start for a skipped plot.
- R9: x_o increments by one (wrapping) on the cycle after done_o, including after a skipped plot. While the block is idle and start_i is low, x_wr_i loads x_wdata_i into x.
- R10: lines_o is 256 when option bit 4 is set and SCREEN_LINES otherwise.
- R11: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_wr_i | input | 1 | Load x while idle |
| x_wdata_i | input | COORD_W | Value loaded into x |
| y_i | input | COORD_W | Pixel row, sampled at start |
| color_i | input | 8 | Colour register |
| option_i | input | 8 | Plot options: bit 0 keep zero, bit 1 dither, bit 4 sprite mode |
| bpp_i | input | 2 | Depth: 0 = 2 bpp, 1 = 4 bpp, 2 = 8 bpp |
| start_i | input | 1 | Start a plot when idle |
| x_o | output | COORD_W | Current x coordinate |
| busy_o | output | 1 | Plot in progress |
| done_o | output | 1 | One-cycle end-of-plot pulse |
| lines_o | output | LINES_W | Screen line count |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_re_o | output | 1 | RAM read; data returns the next cycle |
| mem_we_o | output | 1 | RAM write |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data |

## Verification
On every cycle the assertions check the RAM protocol: a read and a write never share a cycle, each write follows a read at the same address, and a write differs from the data read only in the pixel's bit. They also check that done is a single pulse followed by one x step and that an idle block leaves the RAM alone. Whether the right bytes receive the right colour bits, whether dither and transparency decisions are correct, and how long each depth takes can only be shown by the bench. It does this by comparing the RAM against a shadow model after directed and random plots.

// File: rtl/tile_plot_pkg.sv
package tile_plot_pkg;
  localparam int MAX_PLANES = 8;
  localparam int PLANE_W    = 3;

  typedef enum logic [1:0] {
    BPP2 = 2'd0,
    BPP4 = 2'd1,
    BPP8 = 2'd2
  } bpp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_DONE
  } plot_st_e;

  function automatic bpp_e norm_bpp(logic [1:0] code);
    return (code == 2'd3) ? BPP8 : bpp_e'(code);
  endfunction

  function automatic logic [PLANE_W-1:0] last_plane(bpp_e d);
    case (d)
      BPP2:    return 3'd1;
      BPP4:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/tile_plot_color.sv
module tile_plot_color (
  input  logic [7:0] color_i,
  input  logic       dither_en_i,
  input  logic       parity_i,
  input  logic       keep_zero_i,
  input  logic       full_byte_i,
  output logic [7:0] color_o,
  output logic       skip_o
);
  always_comb begin
    color_o = (dither_en_i && parity_i) ? {4'h0, color_i[7:4]} : color_i;
    if (keep_zero_i)      skip_o = 1'b0;
    else if (full_byte_i) skip_o = (color_o == 8'h00);
    else                  skip_o = (color_o[3:0] == 4'h0);
  end
endmodule

// File: rtl/tile_plot_addr.sv
module tile_plot_addr
  import tile_plot_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int COORD_W       = 8,
  parameter int TILES_PER_ROW = 32
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  bpp_e               bpp_i,
  input  logic [PLANE_W-1:0] plane_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] off_tbl [MAX_PLANES];
  logic [ADDR_W-1:0] tile_idx;
  logic [ADDR_W-1:0] base;

  // plane pairs share a 16-byte block, odd plane is the next byte
  for (genvar g = 0; g < MAX_PLANES; g++) begin : g_off
    assign off_tbl[g] = ADDR_W'((g / 2) * 16 + (g % 2));
  end

  always_comb begin
    tile_idx = ADDR_W'(y_i[COORD_W-1:3]) * ADDR_W'(TILES_PER_ROW)
             + ADDR_W'(x_i[COORD_W-1:3]);
    case (bpp_i)
      BPP2:    base = tile_idx << 4;
      BPP4:    base = tile_idx << 5;
      default: base = tile_idx << 6;
    endcase
    addr_o = base + ADDR_W'({y_i[2:0], 1'b0}) + off_tbl[plane_i];
  end
endmodule

// File: rtl/tile_plot_merge.sv
module tile_plot_merge (
  input  logic [7:0] rdata_i,
  input  logic [2:0] col_i,
  input  logic       bit_i,
  output logic [7:0] wdata_o
);
  // leftmost pixel is bit 7
  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign wdata_o[b] = (col_i == 3'(7 - b)) ? bit_i : rdata_i[b];
  end
endmodule

// File: rtl/tile_plotter.sv
module tile_plotter
  import tile_plot_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int COORD_W       = 8,
  parameter int TILES_PER_ROW = 32,
  parameter int SCREEN_LINES  = 192,
  parameter int LINES_W       = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               x_wr_i,
  input  logic [COORD_W-1:0] x_wdata_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [7:0]         color_i,
  input  logic [7:0]         option_i,
  input  logic [1:0]         bpp_i,
  input  logic               start_i,
  output logic [COORD_W-1:0] x_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [LINES_W-1:0] lines_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i
);
  localparam int OPT_KEEP   = 0;
  localparam int OPT_DITHER = 1;
  localparam int OPT_SPRITE = 4;

  plot_st_e           state_q;
  logic [COORD_W-1:0] x_q, y_q;
  logic [7:0]         col_q;
  bpp_e               bpp_q, bpp_in;
  logic [PLANE_W-1:0] plane_q;
  logic [7:0]         col_sel;
  logic               skip;
  logic               launch;

  assign bpp_in = norm_bpp(bpp_i);
  assign launch = (state_q == ST_IDLE) && start_i;

  tile_plot_color u_color (
    .color_i     (color_i),
    .dither_en_i (option_i[OPT_DITHER]),
    .parity_i    (x_q[0] ^ y_i[0]),
    .keep_zero_i (option_i[OPT_KEEP]),
    .full_byte_i (option_i[OPT_SPRITE] && (bpp_in == BPP8)),
    .color_o     (col_sel),
    .skip_o      (skip)
  );

  tile_plot_addr #(
    .ADDR_W        (ADDR_W),
    .COORD_W       (COORD_W),
    .TILES_PER_ROW (TILES_PER_ROW)
  ) u_addr (
    .x_i     (x_q),
    .y_i     (y_q),
    .bpp_i   (bpp_q),
    .plane_i (plane_q),
    .addr_o  (mem_addr_o)
  );

  tile_plot_merge u_merge (
    .rdata_i (mem_rdata_i),
    .col_i   (x_q[2:0]),
    .bit_i   (col_q[plane_q]),
    .wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      col_q   <= '0;
      bpp_q   <= BPP2;
      plane_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            y_q     <= y_i;
            col_q   <= col_sel;
            bpp_q   <= bpp_in;
            plane_q <= '0;
            state_q <= skip ? ST_DONE : ST_RD;
          end else if (x_wr_i) begin
            x_q <= x_wdata_i;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (plane_q == last_plane(bpp_q)) begin
            state_q <= ST_DONE;
          end else begin
            plane_q <= plane_q + 1'b1;
            state_q <= ST_RD;
          end
        end
        default: begin
          x_q     <= x_q + 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign x_o      = x_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign mem_re_o = (state_q == ST_RD);
  assign mem_we_o = (state_q == ST_WR);
  assign lines_o  = option_i[OPT_SPRITE] ? LINES_W'(256) : LINES_W'(SCREEN_LINES);
endmodule

// File: rtl/tile_plotter_chk.sv
module tile_plotter_chk #(
  parameter int ADDR_W  = 16,
  parameter int COORD_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [COORD_W-1:0] x_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_re_o,
  input logic               mem_we_o,
  input logic [7:0]         mem_wdata_o,
  input logic [7:0]         mem_rdata_i
);
  assert_rw_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_wr_after_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_wr_same_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == $past(mem_addr_o)));

  assert_keep_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (((mem_wdata_o ^ mem_rdata_i) & ~(8'h80 >> x_o[2:0])) == 8'h00));

  assert_x_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (x_o == COORD_W'($past(x_o) + 1'b1)));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !mem_we_o));
endmodule

bind tile_plotter tile_plotter_chk #(
  .ADDR_W  (ADDR_W),
  .COORD_W (COORD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .x_o         (x_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/sim_tile_plotter.sv
module sim_tile_plotter;
  localparam int AW  = 12;
  localparam int TPR = 2;
  localparam int MEM = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x_wr = 1'b0;
  logic [7:0] x_wdata = '0;
  logic [7:0] y = '0;
  logic [7:0] color = '0;
  logic [7:0] option = '0;
  logic [1:0] bpp = '0;
  logic       start = 1'b0;
  logic [7:0] x_o;
  logic       busy, done;
  logic [8:0] lines;
  logic [AW-1:0] addr;
  logic       re, we;
  logic [7:0] wdata;
  logic [7:0] rdata = '0;

  logic [7:0] ram     [MEM];
  logic [7:0] ref_mem [MEM];
  int wr_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  tile_plotter #(
    .ADDR_W(AW), .COORD_W(8), .TILES_PER_ROW(TPR), .SCREEN_LINES(192), .LINES_W(9)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .x_wr_i(x_wr), .x_wdata_i(x_wdata), .y_i(y),
    .color_i(color), .option_i(option), .bpp_i(bpp), .start_i(start),
    .x_o(x_o), .busy_o(busy), .done_o(done), .lines_o(lines),
    .mem_addr_o(addr), .mem_re_o(re), .mem_we_o(we), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) begin
      ram[addr] <= wdata;
      wr_cnt    <= wr_cnt + 1;
    end
    if (re) rdata <= ram[addr];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int exp_addr(input int xv, input int yv, input int bp, input int p);
    return ((((yv >> 3) * TPR + (xv >> 3)) * (16 << bp)) + 2 * (yv & 7)
            + (p >> 1) * 16 + (p & 1)) & (MEM - 1);
  endfunction

  task automatic load_x(input logic [7:0] v);
    x_wr = 1'b1; x_wdata = v;
    @(negedge clk);
    x_wr = 1'b0;
    @(negedge clk);
    chk(x_o == v, "R9", "x load", x_o, v);
  endtask

  task automatic plot(input logic [7:0] yv, input logic [7:0] cv, input logic [7:0] ov,
                      input logic [1:0] bv, input bit poke, input string req);
    logic [7:0] xv, c;
    bit trans;
    int bp, planes, n, w0, exp_n;
    xv = x_o;
    bp = (bv == 2'd3) ? 2 : int'(bv);
    planes = 2 << bp;
    c = (ov[1] && ((xv[0] ^ yv[0]) == 1'b1)) ? {4'h0, cv[7:4]} : cv;
    trans = !ov[0] && ((bp == 2 && ov[4]) ? (c == 8'h00) : (c[3:0] == 4'h0));
    if (!trans)
      for (int p = 0; p < planes; p++)
        ref_mem[exp_addr(xv, yv, bp, p)][7 - xv[2:0]] = c[p];
    y = yv; color = cv; option = ov; bpp = bv; start = 1'b1;
    w0 = wr_cnt;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      if (poke && n == 2) begin start = 1'b1; y = ~yv; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    exp_n = trans ? 0 : 2 * planes;
    chk(n == exp_n, "R8", "cycles to done", n, exp_n);
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    chk(x_o == 8'(xv + 1), "R9", "x step", x_o, 8'(xv + 1));
    chk(wr_cnt - w0 == (trans ? 0 : planes), trans ? "R3" : "R7", "write count",
        wr_cnt - w0, trans ? 0 : planes);
    for (int p = 0; p < planes; p++) begin
      int a = exp_addr(xv, yv, bp, p);
      chk(ram[a] == ref_mem[a], req, $sformatf("plane %0d byte %0h", p, a), ram[a], ref_mem[a]);
    end
    if (poke) begin
      w0 = wr_cnt;
      repeat (4) @(negedge clk);
      chk(!busy && wr_cnt == w0, "R11", "start while busy", wr_cnt - w0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MEM; i++) begin
      ram[i] = 8'($urandom);
      ref_mem[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    chk(x_o == 0 && !done && !busy && !re && !we, "R1", "reset state",
        {x_o, done, busy, re, we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(x_o == 0 && !busy, "R1", "after release", x_o, 0);

    option = 8'h00; #1;
    chk(lines == 9'd192, "R10", "normal lines", lines, 192);
    option = 8'h10; #1;
    chk(lines == 9'd256, "R10", "sprite lines", lines, 256);

    load_x(8'd5);
    plot(8'd3, 8'h5A, 8'h00, 2'd1, 0, "R6");     // 4 bpp plain
    plot(8'd3, 8'hA5, 8'h02, 2'd1, 0, "R2");     // x=6,y=3 odd parity: upper nibble
    plot(8'd3, 8'hA5, 8'h02, 2'd1, 0, "R2");     // x=7,y=3 even parity: lower nibble
    plot(8'd10, 8'h03, 8'h00, 2'd0, 0, "R5");    // 2 bpp
    plot(8'd10, 8'hF0, 8'h00, 2'd0, 0, "R3");    // low nibble zero: skipped
    load_x(8'd1);
    plot(8'd2, 8'h0F, 8'h02, 2'd0, 0, "R3");     // dithered to zero: skipped
    plot(8'd2, 8'h00, 8'h01, 2'd1, 0, "R3");     // keep zero: written
    plot(8'd20, 8'h30, 8'h10, 2'd2, 0, "R4");    // sprite 8 bpp: whole byte nonzero
    plot(8'd20, 8'h30, 8'h00, 2'd2, 0, "R4");    // normal 8 bpp: skipped
    plot(8'd20, 8'h00, 8'h10, 2'd2, 0, "R4");    // sprite, zero: skipped
    plot(8'd40, 8'hC3, 8'h00, 2'd3, 0, "R7");    // code 3 acts as 8 bpp
    plot(8'd33, 8'h96, 8'h00, 2'd2, 1, "R11");   // start pulse while busy
    load_x(8'd255);
    plot(8'd255, 8'h81, 8'h00, 2'd2, 0, "R6");   // corner, x wraps
    chk(x_o == 0, "R9", "x wrap", x_o, 0);

    for (int k = 0; k < 300; k++) begin
      logic [7:0] ov;
      if ($urandom_range(0, 9) == 0) load_x(8'($urandom));
      ov = {3'b000, 1'($urandom), 2'b00, 1'($urandom), 1'($urandom)};
      plot(8'($urandom), 8'($urandom), ov, 2'($urandom_range(0, 2)), 0, "R7");
    end
    summary();
  end
endmodule